// File: doc/BRIEF.md
# Atomic Split-Access 64-bit Timer

A free-running 64-bit time counter that a host reaches through a narrow 32-bit register port. The count is split into a low word and a high word. The host gets a torn-free result as long as it touches the low word first, for reads and for writes alike, so driver code needs no retry loop.

Reading the low word also copies the upper half of the counter into a shadow register in the same cycle. A later read of the high word returns that shadow, even if a carry has crossed bit 31 in the meantime. Writing the low word only stages the value. Writing the high word then loads both halves into the counter in one cycle. A lock bit in a control register stops the counter while software prepares a new value, and clearing the bit lets it run again. The counter advances on a tick derived from the core clock, by default one tick every 200 clocks.

Top module: `split_timer64`

## Requirements
- R1: After reset the counter, the shadow, the staged low word and the lock bit are all zero. A high-word read (address 1) made before any low-word read returns 0, and a control read (address 2) returns 0.
- R2: When the lock is clear, the counter adds one on each tick. A tick comes every TICK_DIV core clocks, and the first one falls on the TICK_DIV-th clock edge after reset is released. With TICK_DIV=5, two low-word reads taken 10 clocks apart differ by exactly 2.
- R3: A low-word read (address 0) returns bits 31:0 of the counter and, in the same cycle, copies bits 63:32 into the shadow. The next high-word read returns that shadow.
- R4: A carry out of bit 31 that happens between a low-word read and the high-word read that follows it does not change the high word returned.
- R5: A high-word read returns the last shadow value, never the live upper half. Only a low-word read updates the shadow.
- R6: A low-word write (address 0) changes only the staged value and leaves the counter as it was. The next high-word write (address 1) loads {high data, staged low} into the counter in one cycle.
- R7: A second low-word write made before a high-word write replaces the staged value.
- R8: A high-word write with nothing staged loads {high data, the counter's live bits 31:0}. Every high-word write clears the staged state.
- R9: In a cycle where a high-word write and a tick coincide, the loaded value wins and that tick is lost.
- R10: Bit 0 of the control register (address 2) is the lock. While it is set the counter holds its value. Reading the control register returns {31'b0, lock} and changes nothing.
- R11: The counter wraps from all ones to zero.
- R12: Read data is registered. It appears after the clock edge that samples the read enable and holds until the next read. Reads of address 3 return 0, and writes to address 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register select: 0 low word, 1 high word, 2 control, 3 unused |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| rd_en | input | 1 | Read strobe, sampled on the rising edge |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |

## Verification
The bench runs with a short tick period. It drives the counter with directed sequences while it is locked, so the expected words are exact constants. It then drives the counter while it runs: across a carry out of bit 31, across a wrap from all ones, and with a high-word write placed exactly on a tick edge. These cases separate a real snapshot from a live upper-half read, and a load that wins the cycle from one that loses to the increment. A random mix of read pairs, lone high reads, single and repeated low writes, bare high writes, lock toggles and idle gaps is then checked against a cycle-level reference model built from the requirements. This shows that staging, shadowing and locking keep working when they interleave freely.

// File: rtl/split_timer_pkg.sv
package split_timer_pkg;
  localparam int SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    REG_LO   = 2'd0,
    REG_HI   = 2'd1,
    REG_CTL  = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/split_timer_tick.sv
module split_timer_tick #(
  parameter int TICK_DIV = 200
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  generate
    if (TICK_DIV <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_div
      localparam logic [PRE_W-1:0] LAST = PRE_W'(TICK_DIV - 1);
      logic [PRE_W-1:0] pre_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            pre_q <= '0;
        else if (pre_q == LAST) pre_q <= '0;
        else                   pre_q <= pre_q + 1'b1;
      end

      assign tick = (pre_q == LAST);

      // R2: ticks are isolated pulses when the divider exceeds one
      assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/split_timer_core.sv
module split_timer_core #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             lock,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;

  // Load beats the increment; the lock only gates the increment.
  function automatic logic [CNT_W-1:0] next_count(
    input logic [CNT_W-1:0] cur,
    input logic             t,
    input logic             lk,
    input logic             ld,
    input logic [CNT_W-1:0] val
  );
    if (ld)            return val;
    else if (t && !lk) return cur + ONE;
    else               return cur;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= next_count(cnt_q, tick, lock, load, load_val);
  end

  assign cnt = cnt_q;

  // R9: a load takes effect on its own edge, whatever the tick does
  assert_load_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)));
  // R10: locked and not loading means frozen
  assert_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && lock) |=> $stable(cnt_q));
  // R2, R11: one step per tick, modulo 2^CNT_W
  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !lock && tick) |=> (cnt_q == $past(cnt_q) + ONE));
  // R2: no tick, no change
  assert_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !tick) |=> $stable(cnt_q));
endmodule

// File: rtl/split_timer_regs.sv
module split_timer_regs
  import split_timer_pkg::*;
#(
  parameter int BUS_W = 32,
  parameter int CNT_W = 2 * BUS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] addr,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [BUS_W-1:0] wdata,
  input  logic [CNT_W-1:0] cnt_in,
  output logic [BUS_W-1:0] rdata,
  output logic             lock,
  output logic             load,
  output logic [CNT_W-1:0] load_val
);
  reg_sel_e         sel;
  logic             rd_lo_evt, rd_hi_evt, rd_ctl_evt;
  logic             wr_lo_evt, wr_hi_evt, wr_ctl_evt;
  logic [BUS_W-1:0] live_lo, live_hi;
  logic [BUS_W-1:0] shadow_q, stage_q, rdata_q;
  logic             stage_ok_q, lock_q;

  // Pick the low half for the load: staged if present, else the live bits.
  function automatic logic [CNT_W-1:0] merge_load(
    input logic [BUS_W-1:0] hi,
    input logic             have_stage,
    input logic [BUS_W-1:0] staged,
    input logic [BUS_W-1:0] live
  );
    return {hi, (have_stage ? staged : live)};
  endfunction

  assign sel        = reg_sel_e'(addr);
  assign live_lo    = cnt_in[BUS_W-1:0];
  assign live_hi    = cnt_in[CNT_W-1:BUS_W];
  assign rd_lo_evt  = rd_en && (sel == REG_LO);
  assign rd_hi_evt  = rd_en && (sel == REG_HI);
  assign rd_ctl_evt = rd_en && (sel == REG_CTL);
  assign wr_lo_evt  = wr_en && (sel == REG_LO);
  assign wr_hi_evt  = wr_en && (sel == REG_HI);
  assign wr_ctl_evt = wr_en && (sel == REG_CTL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q   <= '0;
      stage_q    <= '0;
      stage_ok_q <= 1'b0;
      lock_q     <= 1'b0;
      rdata_q    <= '0;
    end else begin
      if (rd_lo_evt) shadow_q <= live_hi;
      if (rd_en) begin
        case (sel)
          REG_LO:  rdata_q <= live_lo;
          REG_HI:  rdata_q <= shadow_q;
          REG_CTL: rdata_q <= {{(BUS_W-1){1'b0}}, lock_q};
          default: rdata_q <= '0;
        endcase
      end
      if (wr_lo_evt) begin
        stage_q    <= wdata;
        stage_ok_q <= 1'b1;
      end else if (wr_hi_evt) begin
        stage_ok_q <= 1'b0;
      end
      if (wr_ctl_evt) lock_q <= wdata[0];
    end
  end

  assign rdata    = rdata_q;
  assign lock     = lock_q;
  assign load     = wr_hi_evt;
  assign load_val = merge_load(wdata, stage_ok_q, stage_q, live_lo);

  // R3: low read returns live low and snapshots the live high half
  assert_snapshot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo_evt |=> (shadow_q == $past(live_hi)) && (rdata_q == $past(live_lo)));
  // R5: only a low read moves the shadow
  assert_shadow_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_lo_evt |=> $stable(shadow_q));
  // R4, R5: high read returns the shadow, not the live half
  assert_hi_from_shadow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hi_evt |=> (rdata_q == $past(shadow_q)));
  // R7: each low write overwrites the stage
  assert_restage_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo_evt |=> (stage_q == $past(wdata)) && stage_ok_q);
  // R8: a high write consumes the stage
  assert_stage_used_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi_evt |=> !stage_ok_q);
  // R10: control read has no side effect on the lock
  assert_ctl_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ctl_evt && !wr_ctl_evt) |=> $stable(lock_q) && (rdata_q[0] == lock_q));
  // R12: read data holds without a read
  assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata_q));
endmodule

// File: rtl/split_timer64.sv
module split_timer64
  import split_timer_pkg::*;
#(
  parameter int BUS_W    = 32,
  parameter int TICK_DIV = 200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] addr,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [BUS_W-1:0] wdata,
  output logic [BUS_W-1:0] rdata
);
  localparam int CNT_W = 2 * BUS_W;

  logic             tick, lock, load;
  logic [CNT_W-1:0] load_val, cnt;

  split_timer_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  split_timer_core #(.CNT_W(CNT_W)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .lock    (lock),
    .load    (load),
    .load_val(load_val),
    .cnt     (cnt)
  );

  split_timer_regs #(.BUS_W(BUS_W), .CNT_W(CNT_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .wdata   (wdata),
    .cnt_in  (cnt),
    .rdata   (rdata),
    .lock    (lock),
    .load    (load),
    .load_val(load_val)
  );
endmodule

// File: tb/sim_split_timer64.sv
`timescale 1ns/1ps
module sim_split_timer64;
  localparam int DIV = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  split_timer64 #(.BUS_W(32), .TICK_DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .rd_en(rd_en), .wdata(wdata), .rdata(rdata)
  );

  always #2.5 clk = ~clk;

  // Reference model, written from the requirements.
  int          m_cyc;
  logic [63:0] m_cnt;
  logic [31:0] m_sh, m_stage, m_rd;
  logic        m_ok, m_lock;

  function automatic bit is_tick(input int cyc);
    return (cyc % DIV) == (DIV - 1);
  endfunction

  function automatic logic [63:0] ref_next(input logic [63:0] c, input bit ld,
      input logic [63:0] v, input bit t, input bit lk);
    if (ld) return v;
    if (t && !lk) return c + 64'd1;
    return c;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cyc = 0; m_cnt = '0; m_sh = '0; m_stage = '0; m_rd = '0;
      m_ok = 1'b0; m_lock = 1'b0;
    end else begin
      logic [63:0] ld_v;
      bit ld;
      ld = wr_en && addr == 2'd1;
      ld_v = {wdata, (m_ok ? m_stage : m_cnt[31:0])};
      if (rd_en) begin
        case (addr)
          2'd0: m_rd = m_cnt[31:0];
          2'd1: m_rd = m_sh;
          2'd2: m_rd = {31'd0, m_lock};
          default: m_rd = '0;
        endcase
        if (addr == 2'd0) m_sh = m_cnt[63:32];
      end
      m_cnt = ref_next(m_cnt, ld, ld_v, is_tick(m_cyc), m_lock);
      if (wr_en && addr == 2'd0) begin m_stage = wdata; m_ok = 1'b1; end
      else if (ld) m_ok = 1'b0;
      if (wr_en && addr == 2'd2) m_lock = wdata[0];
      m_cyc++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // All bus tasks start and end on a falling edge.
  task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, d2, lo0, hi0;
    void'($urandom(32'd20240611));
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 rdata after reset", rdata, 32'd0);
    bus_rd(2'd1, d); chk("R1 shadow at reset", d, 32'd0);
    bus_rd(2'd2, d); chk("R1 lock at reset", d, 32'd0);
    bus_rd(2'd0, d); chk("R1 low from reset", d, m_rd);

    // R10: lock, control reads without side effect
    bus_wr(2'd2, 32'd1);
    bus_rd(2'd2, d); chk("R10 lock reads 1", d, 32'd1);
    bus_rd(2'd2, d); chk("R10 second control read", d, 32'd1);
    bus_rd(2'd0, lo0);
    idle(20);
    bus_rd(2'd0, d); chk("R10 frozen while locked", d, lo0);

    // R6, R7: staging, replace, atomic load
    bus_wr(2'd0, 32'hAAAA_0001);
    bus_rd(2'd0, d); chk("R6 staged write leaves counter", d, lo0);
    bus_wr(2'd0, 32'h1234_5678);
    bus_wr(2'd1, 32'h0BAD_F00D);
    bus_rd(2'd0, d); chk("R7 replaced stage loaded", d, 32'h1234_5678);
    bus_rd(2'd1, d); chk("R6 high loaded", d, 32'h0BAD_F00D);

    // R8: bare high write keeps live low
    bus_wr(2'd1, 32'h0000_00C3);
    bus_rd(2'd0, d); chk("R8 live low kept", d, 32'h1234_5678);
    bus_rd(2'd1, d); chk("R8 new high", d, 32'h0000_00C3);

    // R12: unused address
    bus_wr(2'd3, 32'd0);
    bus_rd(2'd2, d); chk("R12 write to addr 3 ignored (lock)", d, 32'd1);
    bus_rd(2'd3, d); chk("R12 addr 3 reads zero", d, 32'd0);
    bus_rd(2'd0, d); chk("R12 write to addr 3 ignored (count)", d, 32'h1234_5678);
    idle(4);
    chk("R12 rdata holds", rdata, 32'h1234_5678);

    // R2: rate while running
    bus_wr(2'd2, 32'd0);
    bus_rd(2'd0, lo0);
    idle(9);
    bus_rd(2'd0, d); chk("R2 two ticks in ten clocks", d - lo0, 32'd2);

    // R4, R3, R5: carry between the reads of a pair
    bus_wr(2'd2, 32'd1);
    bus_wr(2'd0, 32'hFFFF_FFFE);
    bus_wr(2'd1, 32'h0000_0007);
    bus_wr(2'd2, 32'd0);
    bus_rd(2'd0, d); chk("R4 low before carry", d, m_rd);
    idle(20);
    bus_rd(2'd1, d); chk("R4 high from snapshot", d, 32'h0000_0007);
    bus_rd(2'd0, d); chk("R3 low after carry", d, m_rd);
    bus_rd(2'd1, d); chk("R3 fresh snapshot", d, 32'h0000_0008);
    bus_wr(2'd2, 32'd1);
    bus_wr(2'd0, 32'h0);
    bus_wr(2'd1, 32'h0000_0055);
    bus_rd(2'd1, d); chk("R5 high not live", d, 32'h0000_0008);

    // R11: wrap
    bus_wr(2'd0, 32'hFFFF_FFFF);
    bus_wr(2'd1, 32'hFFFF_FFFF);
    bus_wr(2'd2, 32'd0);
    idle(10);
    bus_wr(2'd2, 32'd1);
    bus_rd(2'd0, d); chk("R11 low after wrap", d, m_rd);
    bus_rd(2'd1, d); chk("R11 high after wrap", d, 32'd0);

    // R9: load on a tick edge
    bus_wr(2'd2, 32'd0);
    bus_wr(2'd0, 32'h0000_0100);
    while (!is_tick(m_cyc)) @(negedge clk);
    bus_wr(2'd1, 32'h0000_0042);
    bus_rd(2'd0, d); chk("R9 load beats tick (low)", d, 32'h0000_0100);
    bus_rd(2'd1, d); chk("R9 load beats tick (high)", d, 32'h0000_0042);

    // Random mix against the model
    for (int it = 0; it < 600; it++) begin
      int op;
      op = $urandom_range(0, 7);
      case (op)
        0, 1: begin
          bus_rd(2'd0, d);  chk("R3 random low", d, m_rd);
          idle($urandom_range(0, 6));
          bus_rd(2'd1, d2); chk("R4 random high of pair", d2, m_rd);
        end
        2: begin bus_rd(2'd1, d); chk("R5 random lone high", d, m_rd); end
        3: bus_wr(2'd0, ($urandom_range(0, 1) != 0) ? (32'hFFFF_FFF0 + $urandom_range(0, 15)) : $urandom);
        4: bus_wr(2'd1, $urandom);
        5: begin
          bus_wr(2'd2, $urandom);
          bus_rd(2'd2, d); chk("R10 random control", d, m_rd);
        end
        6: begin
          bus_rd(2'($urandom_range(2, 3)), d); chk("R12 random ctl/unused read", d, m_rd);
        end
        default: idle($urandom_range(0, 12));
      endcase
    end
    bus_rd(2'd0, d); chk("R6 final low", d, m_rd);
    bus_rd(2'd1, d); chk("R6 final high", d, m_rd);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule